// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a processor reach a small bank of 8-bit internal registers through two 32-bit bus windows. The command window holds three fields: a register index, a write byte and a write request bit. The data window returns the byte that was last fetched from the selected register, together with an interrupt flag.

Setting the request bit starts a write. The write takes a fixed number of cycles. The request bit reads back as 1 until hardware clears it, and the bus must wait for that before issuing the next access. A read starts when software writes the command window with the request bit clear. The addressed byte reaches the data window after a fixed settling delay.

The register bank has the following features:
- Registers that are not tied off come out of reset with fixed values.
- Two test slots are blocked.
- Indexes above the bank are not implemented.
- A status register collects two ramp-completion pulses from the analog side. Software clears each of its two flags by writing a zero to that flag's bit.

Top module: `ind_bridge_top`

## Requirements
- R1: A bus write to offset 0x0 loads the command window. Its read-back holds the data byte in bits 7:0, the 7-bit index in bits 14:8 and the busy flag in bit 16, and every other bit reads 0. A read at offset 0x4 returns the data window. Offsets other than 0x0 and 0x4 read 0 and ignore writes.
- R2: A command write with bit 16 set starts a write. Bit 16 reads 1 for exactly WR_LAT (4) cycles and then 0. When bit 16 drops, the indexed register holds the data byte.
- R3: While bit 16 reads 1, command writes are ignored. The index, the data byte and every register keep their values.
- R4: Any accepted command write restarts the read delay. Bits 7:0 of the data window keep their previous value for RD_LAT-1 (5) cycles after the update edge. From the RD_LAT-th (6th) cycle on, they show the newly indexed register.
- R5: At reset, the command window reads 0 and the interrupt is clear. Indexes 0 to 8 hold 0x0c, 0xaa, 0x78, 0x00, 0x00, 0xff, 0x03, 0x51, 0x3f, and every other implemented index holds 0.
- R6: Indexes 20 and 21 always read 0, and writes to them have no effect.
- R7: Indexes 28 to 127 always read 0, and writes to them have no effect.
- R8: Index 9 is the status register. A ramp_up_i pulse sets its bit 3 and a ramp_down_i pulse sets its bit 2. A write to index 9 clears each of these two flags whose data bit is 0 and leaves set each flag whose data bit is 1. Its other bits read 0.
- R9: Bit 8 of the data window and irq_o go to 1 in the cycle after either status flag changes from 0 to 1. They return to 0 when a write to index 9 completes. A pulse on a flag that is already set does not raise them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | BUS_AW | Byte offset of the window |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational, 0 when idle |
| ramp_up_i | input | 1 | Ramp-up completion pulse |
| ramp_down_i | input | 1 | Ramp-down completion pulse |
| irq_o | output | 1 | Interrupt flag, the same as data window bit 8 |

## Verification
The bench builds the block with its default parameters: 28 registers, a write time of 4 cycles, a read delay of 6 cycles and a 4-bit window offset. With these values it can reach both blocked test slots and the full 7-bit index range, including index 127, and it can observe the busy window and the stale-data window cycle by cycle.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int unsigned REG_DW     = 8;
  localparam int unsigned REG_AW     = 7;
  localparam int unsigned NUM_REGS   = 28;
  localparam int unsigned STAT_IDX   = 9;
  localparam int unsigned TEST_IDX0  = 20;
  localparam int unsigned TEST_IDX1  = 21;
  localparam int unsigned FLAG_UP    = 3;
  localparam int unsigned FLAG_DN    = 2;
  localparam int unsigned STROBE_BIT = 16;
  localparam int unsigned ADDR_LSB   = 8;
  localparam int unsigned IRQ_BIT    = 8;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'h0c;
      1:       return 8'haa;
      2:       return 8'h78;
      5:       return 8'hff;
      6:       return 8'h03;
      7:       return 8'h51;
      8:       return 8'h3f;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ind_bridge_regfile.sv
module ind_bridge_regfile
  import ind_bridge_pkg::*;
#(
  parameter int unsigned NREG = NUM_REGS,
  parameter int unsigned DW   = REG_DW,
  parameter int unsigned AW   = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ramp_up_i,
  input  logic          ramp_down_i,
  output logic          irq_o
);
  localparam int unsigned IW = $clog2(NREG);

  logic [DW-1:0] rd_vec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [AW-1:0] MY_IDX = AW'(g);
    logic sel;
    assign sel = we_i && (waddr_i == MY_IDX);

    if (g == STAT_IDX) begin : g_stat
      logic up_q, dn_q, irq_q;
      logic rise;
      assign rise = (ramp_up_i & ~up_q) | (ramp_down_i & ~dn_q);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          up_q  <= 1'b0;
          dn_q  <= 1'b0;
          irq_q <= 1'b0;
        end else begin
          // write-0-to-clear, pulse wins
          up_q <= ramp_up_i   | (up_q & ~(sel & ~wdata_i[FLAG_UP]));
          dn_q <= ramp_down_i | (dn_q & ~(sel & ~wdata_i[FLAG_DN]));
          if (rise)     irq_q <= 1'b1;
          else if (sel) irq_q <= 1'b0;
        end
      end
      always_comb begin
        rd_vec[g]          = '0;
        rd_vec[g][FLAG_UP] = up_q;
        rd_vec[g][FLAG_DN] = dn_q;
      end
      assign irq_o = irq_q;

      assert_up_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ramp_up_i |=> up_q);
      assert_dn_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ramp_down_i |=> dn_q);
      assert_irq_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(up_q) || $rose(dn_q)) |-> irq_q);
    end else if (g == TEST_IDX0 || g == TEST_IDX1) begin : g_test
      assign rd_vec[g] = '0;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= DW'(reg_default(g));
        else if (sel) q <= wdata_i;
      end
      assign rd_vec[g] = q;
    end
  end

  if (NREG <= STAT_IDX) begin : g_no_stat
    assign irq_o = 1'b0;
  end

  assign rdata_o = (raddr_i < AW'(NREG)) ? rd_vec[raddr_i[IW-1:0]] : '0;

  always_comb begin
    if (rst_ni && (raddr_i == AW'(TEST_IDX0) || raddr_i == AW'(TEST_IDX1)))
      assert_test_zero_R6: assert (rdata_o == '0);
  end
endmodule

// File: rtl/ind_bridge_seq.sv
module ind_bridge_seq
  import ind_bridge_pkg::*;
#(
  parameter int unsigned WR_LAT = 4,
  parameter int unsigned RD_LAT = 6,
  parameter int unsigned DW     = REG_DW,
  parameter int unsigned AW     = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          cmd_strobe_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          rf_we_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned WCW = $clog2(WR_LAT + 1);
  localparam int unsigned RCW = $clog2(RD_LAT + 1);

  logic           busy_q;
  logic [WCW-1:0] wcnt_q;
  logic [RCW-1:0] rcnt_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [DW-1:0]  rd_q;
  logic           accept;

  assign accept = cmd_we_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
      rcnt_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
        rcnt_q <= RCW'(RD_LAT);
        if (cmd_strobe_i) begin
          busy_q <= 1'b1;
          wcnt_q <= WCW'(WR_LAT);
        end
      end else if (rcnt_q != '0) begin
        rcnt_q <= rcnt_q - 1'b1;
      end
      if (busy_q) begin
        wcnt_q <= wcnt_q - 1'b1;
        if (wcnt_q == WCW'(1)) busy_q <= 1'b0;
      end
      // hold stale data while the read settles
      if (rcnt_q <= RCW'(1)) rd_q <= rf_rdata_i;
    end
  end

  assign rf_we_o   = busy_q && (wcnt_q == WCW'(1));
  assign busy_o    = busy_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign rd_data_o = rd_q;

  // checker: busy run length
  logic [WCW:0] blen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blen_q <= '0;
    else if (busy_q) blen_q <= blen_q + 1'b1;
    else             blen_q <= '0;
  end

  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (blen_q < (WCW+1)'(WR_LAT)));
  assert_busy_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(addr_q) && $stable(data_q)));
  assert_rd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcnt_q > RCW'(1)) |=> $stable(rd_q));
endmodule

// File: rtl/ind_bridge_top.sv
module ind_bridge_top
  import ind_bridge_pkg::*;
#(
  parameter int unsigned NREG   = NUM_REGS,
  parameter int unsigned WR_LAT = 4,
  parameter int unsigned RD_LAT = 6,
  parameter int unsigned BUS_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ramp_up_i,
  input  logic              ramp_down_i,
  output logic              irq_o
);
  localparam int unsigned DW       = REG_DW;
  localparam int unsigned AW       = REG_AW;
  localparam logic [BUS_AW-1:0] CMD_OFF  = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] DATA_OFF = BUS_AW'(4);

  logic          cmd_we, busy, rf_we, irq;
  logic [AW-1:0] addr;
  logic [DW-1:0] data, rf_rdata, rd_data;

  assign cmd_we = bus_req_i & bus_we_i & (bus_addr_i == CMD_OFF);

  ind_bridge_seq #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT), .DW(DW), .AW(AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we),
    .cmd_strobe_i (bus_wdata_i[STROBE_BIT]),
    .cmd_addr_i   (bus_wdata_i[ADDR_LSB +: AW]),
    .cmd_data_i   (bus_wdata_i[DW-1:0]),
    .busy_o       (busy),
    .addr_o       (addr),
    .data_o       (data),
    .rf_we_o      (rf_we),
    .rf_rdata_i   (rf_rdata),
    .rd_data_o    (rd_data)
  );

  ind_bridge_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (rf_we),
    .waddr_i     (addr),
    .wdata_i     (data),
    .raddr_i     (addr),
    .rdata_o     (rf_rdata),
    .ramp_up_i   (ramp_up_i),
    .ramp_down_i (ramp_down_i),
    .irq_o       (irq)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (bus_addr_i == CMD_OFF) begin
        bus_rdata_o[STROBE_BIT]       = busy;
        bus_rdata_o[ADDR_LSB +: AW]   = addr;
        bus_rdata_o[DW-1:0]           = data;
      end else if (bus_addr_i == DATA_OFF) begin
        bus_rdata_o[IRQ_BIT]          = irq;
        bus_rdata_o[DW-1:0]           = rd_data;
      end
    end
  end

  assign irq_o = irq;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[31:17], bus_wdata_i[15]};

  assert_no_write_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rf_we) |=> busy);
endmodule

// File: tb/ind_bridge_top_tb.sv
module ind_bridge_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  baddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rup = 1'b0, rdn = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ind_bridge_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(baddr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ramp_up_i(rup), .ramp_down_i(rdn), .irq_o(irq)
  );

  // {index, write byte, expected read}
  localparam logic [22:0] VEC [8] = '{
    {7'd1,   8'h5a, 8'h5a},
    {7'd27,  8'h81, 8'h81},
    {7'd20,  8'hff, 8'h00},
    {7'd21,  8'h33, 8'h00},
    {7'd28,  8'h77, 8'h00},
    {7'd127, 8'h12, 8'h00},
    {7'd0,   8'hc3, 8'hc3},
    {7'd8,   8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; baddr = off; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic peek(input logic [3:0] off, output logic [31:0] d);
    req = 1'b1; we = 1'b0; baddr = off;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] v);
    bus_wr(4'h0, 32'h1_0000 | (idx << 8) | 32'(v));
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] v, output logic irqf);
    logic [31:0] d;
    bus_wr(4'h0, idx << 8);
    repeat (6) @(negedge clk);
    peek(4'h4, d);
    v = d[7:0];
    irqf = d[8];
  endtask

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) rup = 1'b1; else rdn = 1'b1;
    @(negedge clk);
    rup = 1'b0; rdn = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  v;
    logic        f;
    logic [7:0]  dflt [9];
    dflt = '{8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03, 8'h51, 8'h3f};

    // R5 reset state
    repeat (2) @(negedge clk);
    peek(4'h0, d);
    check("R5 cmd window in reset", d, 32'h0);
    check("R5 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    peek(4'h4, d);
    check("R5 data window after reset", d, 32'h0c);

    for (int i = 0; i < 9; i++) begin
      rd_reg(i, v, f);
      check($sformatf("R5 default idx %0d", i), {24'b0, v}, {24'b0, dflt[i]});
    end
    rd_reg(15, v, f);
    check("R5 default idx 15", {24'b0, v}, 32'h0);

    // R1 field layout and offsets
    bus_wr(4'h0, 32'h0000_3ba5);
    peek(4'h0, d);
    check("R1 cmd readback", d, 32'h0000_3ba5);
    bus_wr(4'h8, 32'h1_0000);
    peek(4'h8, d);
    check("R1 other offset reads 0", d, 32'h0);
    peek(4'h0, d);
    check("R1 other offset write ignored", d, 32'h0000_3ba5);

    // vector table: R2 / R6 / R7
    for (int i = 0; i < 8; i++) begin
      int idx;
      string tag;
      idx = int'(VEC[i][22:16]);
      tag = (idx == 20 || idx == 21) ? "R6" : (idx >= 28) ? "R7" : "R2";
      wr_reg(idx, VEC[i][15:8]);
      rd_reg(idx, v, f);
      check($sformatf("%s table idx %0d", tag, idx), {24'b0, v}, {24'b0, VEC[i][7:0]});
    end

    // R2 busy window
    bus_wr(4'h0, 32'h1_0455);
    peek(4'h0, d);
    check("R2 busy after strobe", {31'b0, d[16]}, 32'h1);
    repeat (3) @(negedge clk);
    peek(4'h0, d);
    check("R2 busy in last cycle", {31'b0, d[16]}, 32'h1);
    @(negedge clk);
    peek(4'h0, d);
    check("R2 busy cleared", d, 32'h0000_0455);
    rd_reg(4, v, f);
    check("R2 data written", {24'b0, v}, 32'h55);

    // R3 write while busy ignored
    bus_wr(4'h0, 32'h1_0211);
    bus_wr(4'h0, 32'h1_0322);
    repeat (3) @(negedge clk);
    peek(4'h0, d);
    check("R3 cmd fields kept", d, 32'h0000_0211);
    rd_reg(3, v, f);
    check("R3 ignored target unchanged", {24'b0, v}, 32'h0);
    rd_reg(2, v, f);
    check("R3 first write landed", {24'b0, v}, 32'h11);

    // R4 read latency
    rd_reg(1, v, f);
    check("R4 settled idx 1", {24'b0, v}, 32'h5a);
    bus_wr(4'h0, 32'h0000_1b00);
    repeat (5) @(negedge clk);
    peek(4'h4, d);
    check("R4 stale before delay", {24'b0, d[7:0]}, 32'h5a);
    @(negedge clk);
    peek(4'h4, d);
    check("R4 new data at delay", {24'b0, d[7:0]}, 32'h81);

    // R8 / R9 status flags and interrupt
    check("R9 irq idle", {31'b0, irq}, 32'h0);
    pulse(1'b1);
    rd_reg(9, v, f);
    check("R8 ramp up sets bit 3", {24'b0, v}, 32'h08);
    check("R9 irq on rise", {31'b0, f}, 32'h1);
    check("R9 irq pin", {31'b0, irq}, 32'h1);
    wr_reg(9, 8'hff);
    rd_reg(9, v, f);
    check("R8 write ones keeps flag", {24'b0, v}, 32'h08);
    check("R9 irq cleared by write", {31'b0, f}, 32'h0);
    pulse(1'b0);
    rd_reg(9, v, f);
    check("R8 ramp down sets bit 2", {24'b0, v}, 32'h0c);
    check("R9 irq on second rise", {31'b0, f}, 32'h1);
    wr_reg(9, 8'h04);
    rd_reg(9, v, f);
    check("R8 write zero clears bit 3", {24'b0, v}, 32'h04);
    check("R9 irq cleared", {31'b0, f}, 32'h0);
    pulse(1'b0);
    rd_reg(9, v, f);
    check("R9 no irq without rise", {31'b0, f}, 32'h0);
    check("R8 flag stays set", {24'b0, v}, 32'h04);

    finish_run();
  end
endmodule